// File: doc/BRIEF.md
# Byte-serial instruction field parser

This block takes a stream of instruction bytes, one per cycle, and splits each instruction into its parts. These are up to four option prefixes, an opcode of one byte or two (escape plus opcode), an optional operand-form byte, an optional scaled-index byte, a displacement and an immediate. For every instruction it hands out one record. The record carries:
- the prefix flags;
- the opcode;
- the raw operand-form and scaled-index bytes, each with a presence flag;
- the displacement and immediate values with their byte counts;
- the total length;
- an error flag.

The decoder covers only the 32-bit default mode and the integer-add opcode family. Any other opcode ends the instruction with an error record.

Both edges of the block are valid/ready streams:
- A byte moves when `in_valid` and `in_ready` are both high at a clock edge.
- A record moves when `out_valid` and `out_ready` are both high.
- The block holds only one output record. While that record waits and `out_ready` is low, `in_ready` is low, so parsing stalls even in the middle of an instruction.
- A record that is waiting keeps all its fields unchanged until it is taken.
- A new record may be loaded in the same cycle as the old one is taken.

Top module: `isp_parser`

## Requirements
- R1: `in_ready` equals NOT(`out_valid` AND NOT `out_ready`). A waiting record holds every output field stable until it is taken.
- R2: Reset (active-low `rst_n`) drops `out_valid` and discards any partly parsed instruction. The next byte is then taken as the start of a new instruction, with every prefix flag clear.
- R3: Prefix bytes set the record flags as follows:
  - `out_lockrep`: F0h gives 1, F2h gives 2, F3h gives 3.
  - `out_seg`: 26h gives 1, 64h gives 2.
  - 66h sets `out_opsz16` and 67h sets `out_adsz16`.
  - A later prefix in the same group replaces the earlier value.
- R4: A fifth prefix byte in a row ends the instruction. The record has `out_err`=1 and length 5, and the fifth prefix is not applied to the flags.
- R5: A first opcode byte of 0Fh sets `out_escape`. The following byte is consumed as the opcode, and the record is an error record.
- R6: The opcodes accepted are 00h–03h, 04h, 05h, 80h, 81h and 83h. Any other opcode ends the instruction with `out_err`=1 as soon as the opcode byte is consumed.
- R7: Opcodes 00h–03h and 80h/81h/83h read an operand-form byte. Its mode field is bits 7:6 and its rm field is bits 2:0. A scaled-index byte follows when the mode is not 3 and rm is 4.
- R8: The displacement length is set by the operand-form byte and, when present, the scaled-index byte:
  - mode 1 gives 1 byte;
  - mode 2 gives 4 bytes;
  - mode 0 with rm 5 gives 4 bytes;
  - mode 0 with a scaled-index base (bits 2:0) of 5 gives 4 bytes;
  - every other case gives 0.
- R9: The displacement comes first and the immediate after it. Both are assembled little-endian: the first byte goes in bits 7:0.
- R10: The immediate is 1 byte for 04h, 80h and 83h. For 05h and 81h it is 4 bytes, or 2 bytes when 66h was seen. The other accepted opcodes have no immediate.
- R11: `out_len` counts every byte consumed for the instruction. A 15-byte instruction is accepted without error. A byte that would go past `MAX_LEN` ends the instruction as an error.
- R12: Fields that are absent read as zero: their presence flag, their length and their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_lockrep | output | 2 | Lock/repeat prefix code |
| out_seg | output | 2 | Segment override code |
| out_opsz16 | output | 1 | Operand-size override seen |
| out_adsz16 | output | 1 | Address-size override seen |
| out_escape | output | 1 | Two-byte opcode escape seen |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | Operand-form byte present |
| out_modrm | output | 8 | Raw operand-form byte |
| out_has_sib | output | 1 | Scaled-index byte present |
| out_sib | output | 8 | Raw scaled-index byte |
| out_disp | output | 32 | Displacement value |
| out_disp_len | output | 3 | Displacement byte count |
| out_imm | output | 32 | Immediate value |
| out_imm_len | output | 3 | Immediate byte count |
| out_len | output | $clog2(MAX_LEN+1) | Instruction length in bytes |
| out_err | output | 1 | Instruction is illegal or unsupported |

## Verification
The bench drives the following input patterns:
- **Register-only forms** separate the operand-form path from the scaled-index path.
- **Memory forms with 1-byte and 4-byte displacements** expose mistakes in the mode decode and in the little-endian byte order.
- **The no-base forms** (rm 5 in mode 0, and scaled-index base 5 in mode 0) test the two special cases that add a displacement with no mode bits asking for one.
- **Immediate forms with and without 66h** separate the 4-byte and 2-byte immediate widths.
- **A maximum-length instruction** checks that the length limit is not off by one.
- **Error streams** (five prefixes, escape, unknown opcode), each followed by a legal instruction, show that the parser returns cleanly to prefix collection.
- **A truncated instruction cut off by reset** checks R2.

Back-pressure from `out_ready` and gaps in `in_valid` are varied throughout, so the stall rule is exercised while bytes are still in flight.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int FIELD_BYTES = 4;
  localparam int FIELD_W     = 8 * FIELD_BYTES;

  typedef enum logic [2:0] {
    ST_PFX, ST_ESC, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } st_e;

  typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_FULL} imm_e;

  typedef enum logic [2:0] {
    PG_NONE, PG_LOCKREP, PG_SEG, PG_OPSZ, PG_ADSZ
  } pgrp_e;

  typedef struct packed {
    logic [1:0]         lockrep;
    logic [1:0]         seg;
    logic               opsz16;
    logic               adsz16;
    logic               esc;
    logic [7:0]         opcode;
    logic               has_modrm;
    logic [7:0]         modrm;
    logic               has_sib;
    logic [7:0]         sib;
    logic [FIELD_W-1:0] disp;
    logic [2:0]         disp_len;
    logic [FIELD_W-1:0] imm;
    logic [2:0]         imm_len;
    logic               err;
  } rec_t;
endpackage

// File: rtl/isp_prefix_class.sv
module isp_prefix_class
  import isp_pkg::*;
(
  input  logic [7:0] byte_i,
  output pgrp_e      grp_o,
  output logic [1:0] code_o
);
  always_comb begin
    grp_o  = PG_NONE;
    code_o = 2'd0;
    case (byte_i)
      8'hF0:   begin grp_o = PG_LOCKREP; code_o = 2'd1; end
      8'hF2:   begin grp_o = PG_LOCKREP; code_o = 2'd2; end
      8'hF3:   begin grp_o = PG_LOCKREP; code_o = 2'd3; end
      8'h26:   begin grp_o = PG_SEG;     code_o = 2'd1; end
      8'h64:   begin grp_o = PG_SEG;     code_o = 2'd2; end
      8'h66:   grp_o = PG_OPSZ;
      8'h67:   grp_o = PG_ADSZ;
      default: grp_o = PG_NONE;
    endcase
  end
endmodule

// File: rtl/isp_op_table.sv
module isp_op_table
  import isp_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       ok_o,
  output logic       modrm_o,
  output imm_e       imm_o
);
  always_comb begin
    ok_o    = 1'b1;
    modrm_o = 1'b0;
    imm_o   = IMM_NONE;
    case (op_i)
      8'h00, 8'h01, 8'h02, 8'h03: modrm_o = 1'b1;
      8'h04:                      imm_o = IMM_BYTE;
      8'h05:                      imm_o = IMM_FULL;
      8'h80, 8'h83:               begin modrm_o = 1'b1; imm_o = IMM_BYTE; end
      8'h81:                      begin modrm_o = 1'b1; imm_o = IMM_FULL; end
      default:                    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/isp_addr_form.sv
module isp_addr_form (
  input  logic [1:0] mode_i,
  input  logic [2:0] rm_i,
  input  logic [2:0] sib_base_i,
  output logic       want_sib_o,
  output logic [2:0] disp_modrm_o,
  output logic [2:0] disp_sib_o
);
  assign want_sib_o = (mode_i != 2'd3) && (rm_i == 3'd4);

  always_comb begin
    case (mode_i)
      2'd1:    disp_modrm_o = 3'd1;
      2'd2:    disp_modrm_o = 3'd4;
      2'd0:    disp_modrm_o = (rm_i == 3'd5) ? 3'd4 : 3'd0;
      default: disp_modrm_o = 3'd0;
    endcase
  end

  assign disp_sib_o = ((mode_i == 2'd0) && (sib_base_i == 3'd5)) ? 3'd4 : 3'd0;
endmodule

// File: rtl/isp_parser.sv
module isp_parser
  import isp_pkg::*;
#(
  parameter  int MAX_LEN = 15,
  parameter  int MAX_PFX = 4,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int PCNT_W  = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_lockrep,
  output logic [1:0]       out_seg,
  output logic             out_opsz16,
  output logic             out_adsz16,
  output logic             out_escape,
  output logic [7:0]       out_opcode,
  output logic             out_has_modrm,
  output logic [7:0]       out_modrm,
  output logic             out_has_sib,
  output logic [7:0]       out_sib,
  output logic [31:0]      out_disp,
  output logic [2:0]       out_disp_len,
  output logic [31:0]      out_imm,
  output logic [2:0]       out_imm_len,
  output logic [LEN_W-1:0] out_len,
  output logic             out_err
);
  st_e               st_q, st_d;
  rec_t              w_q, w_d, rec_q;
  logic [LEN_W-1:0]  len_q, len_d, rec_len_q;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [1:0]        idx_q, idx_d;
  logic              rec_vld_q, done, take;

  pgrp_e      pg;
  logic [1:0] pcode;
  logic       op_ok, op_modrm;
  imm_e       op_imm;
  logic       want_sib;
  logic [2:0] disp_modrm, disp_sib, sib_dl;
  logic [7:0] form_byte;

  isp_prefix_class u_pfx (.byte_i(in_byte), .grp_o(pg), .code_o(pcode));
  isp_op_table u_op (.op_i(in_byte), .ok_o(op_ok), .modrm_o(op_modrm), .imm_o(op_imm));

  assign form_byte = (st_q == ST_MODRM) ? in_byte : w_q.modrm;
  isp_addr_form u_form (
    .mode_i(form_byte[7:6]), .rm_i(form_byte[2:0]), .sib_base_i(in_byte[2:0]),
    .want_sib_o(want_sib), .disp_modrm_o(disp_modrm), .disp_sib_o(disp_sib)
  );
  assign sib_dl = (disp_sib != 3'd0) ? disp_sib : w_q.disp_len;

  assign in_ready = !(rec_vld_q && !out_ready);
  assign take     = in_valid && in_ready;

  always_comb begin
    st_d   = st_q;
    w_d    = w_q;
    len_d  = len_q + 1'b1;
    pcnt_d = pcnt_q;
    idx_d  = idx_q;
    done   = 1'b0;
    if (take) begin
      if (len_q == LEN_W'(MAX_LEN)) begin
        w_d.err = 1'b1;
        len_d   = len_q;
        done    = 1'b1;
      end else begin
        case (st_q)
          ST_PFX: begin
            if (pg != PG_NONE) begin
              if (pcnt_q == PCNT_W'(MAX_PFX)) begin
                w_d.err = 1'b1;
                done    = 1'b1;
              end else begin
                pcnt_d = pcnt_q + 1'b1;
                case (pg)
                  PG_LOCKREP: w_d.lockrep = pcode;
                  PG_SEG:     w_d.seg     = pcode;
                  PG_OPSZ:    w_d.opsz16  = 1'b1;
                  PG_ADSZ:    w_d.adsz16  = 1'b1;
                  default:    ;
                endcase
              end
            end else if (in_byte == 8'h0F) begin
              w_d.esc = 1'b1;
              st_d    = ST_ESC;
            end else begin
              w_d.opcode = in_byte;
              if (!op_ok) begin
                w_d.err = 1'b1;
                done    = 1'b1;
              end else begin
                case (op_imm)
                  IMM_BYTE: w_d.imm_len = 3'd1;
                  IMM_FULL: w_d.imm_len = w_q.opsz16 ? 3'd2 : 3'd4;
                  default:  w_d.imm_len = 3'd0;
                endcase
                st_d  = op_modrm ? ST_MODRM : ST_IMM;
                idx_d = 2'd0;
              end
            end
          end
          ST_ESC: begin
            w_d.opcode = in_byte;
            w_d.err    = 1'b1;
            done       = 1'b1;
          end
          ST_MODRM: begin
            w_d.has_modrm = 1'b1;
            w_d.modrm     = in_byte;
            w_d.disp_len  = disp_modrm;
            idx_d         = 2'd0;
            if (want_sib)                st_d = ST_SIB;
            else if (disp_modrm != 3'd0) st_d = ST_DISP;
            else if (w_q.imm_len != 3'd0) st_d = ST_IMM;
            else                         done = 1'b1;
          end
          ST_SIB: begin
            w_d.has_sib  = 1'b1;
            w_d.sib      = in_byte;
            w_d.disp_len = sib_dl;
            if (sib_dl != 3'd0)           st_d = ST_DISP;
            else if (w_q.imm_len != 3'd0) st_d = ST_IMM;
            else                          done = 1'b1;
          end
          ST_DISP: begin
            w_d.disp[{idx_q, 3'b000} +: 8] = in_byte;
            idx_d = idx_q + 2'd1;
            if (idx_q == 2'(w_q.disp_len - 3'd1)) begin
              idx_d = 2'd0;
              if (w_q.imm_len != 3'd0) st_d = ST_IMM;
              else                     done = 1'b1;
            end
          end
          ST_IMM: begin
            w_d.imm[{idx_q, 3'b000} +: 8] = in_byte;
            idx_d = idx_q + 2'd1;
            if (idx_q == 2'(w_q.imm_len - 3'd1)) done = 1'b1;
          end
          default: st_d = ST_PFX;
        endcase
      end
    end else begin
      len_d = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_PFX;
      w_q       <= '0;
      len_q     <= '0;
      pcnt_q    <= '0;
      idx_q     <= '0;
      rec_q     <= '0;
      rec_len_q <= '0;
      rec_vld_q <= 1'b0;
    end else if (done) begin
      rec_q     <= w_d;
      rec_len_q <= len_d;
      rec_vld_q <= 1'b1;
      st_q      <= ST_PFX;
      w_q       <= '0;
      len_q     <= '0;
      pcnt_q    <= '0;
      idx_q     <= '0;
    end else begin
      st_q   <= st_d;
      w_q    <= w_d;
      len_q  <= len_d;
      pcnt_q <= pcnt_d;
      idx_q  <= idx_d;
      if (out_ready) rec_vld_q <= 1'b0;
    end
  end

  assign out_valid     = rec_vld_q;
  assign out_lockrep   = rec_q.lockrep;
  assign out_seg       = rec_q.seg;
  assign out_opsz16    = rec_q.opsz16;
  assign out_adsz16    = rec_q.adsz16;
  assign out_escape    = rec_q.esc;
  assign out_opcode    = rec_q.opcode;
  assign out_has_modrm = rec_q.has_modrm;
  assign out_modrm     = rec_q.modrm;
  assign out_has_sib   = rec_q.has_sib;
  assign out_sib       = rec_q.sib;
  assign out_disp      = rec_q.disp;
  assign out_disp_len  = rec_q.disp_len;
  assign out_imm       = rec_q.imm;
  assign out_imm_len   = rec_q.imm_len;
  assign out_len       = rec_len_q;
  assign out_err       = rec_q.err;
endmodule

// File: rtl/isp_parser_chk.sv
module isp_parser_chk #(
  parameter  int MAX_LEN = 15,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_opsz16,
  input logic             out_escape,
  input logic [7:0]       out_opcode,
  input logic             out_has_modrm,
  input logic             out_has_sib,
  input logic [31:0]      out_disp,
  input logic [2:0]       out_disp_len,
  input logic [2:0]       out_imm_len,
  input logic [LEN_W-1:0] out_len,
  input logic             out_err
);
  a_r1_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r1_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_len)
                                   && $stable(out_disp) && $stable(out_err)));

  a_r11_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= LEN_W'(MAX_LEN)));

  a_r8_disp_size: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_disp_len == 3'd0 || out_disp_len == 3'd1 || out_disp_len == 3'd4));

  a_r7_sib_after_modrm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_sib) |-> out_has_modrm);

  a_r10_short_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imm_len == 3'd2) |-> out_opsz16);

  a_r5_escape_err: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_escape) |-> out_err);

  a_r12_no_disp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_disp_len == 3'd0) |-> (out_disp == 32'd0));
endmodule

bind isp_parser isp_parser_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_opsz16(out_opsz16), .out_escape(out_escape),
  .out_opcode(out_opcode), .out_has_modrm(out_has_modrm), .out_has_sib(out_has_sib),
  .out_disp(out_disp), .out_disp_len(out_disp_len), .out_imm_len(out_imm_len),
  .out_len(out_len), .out_err(out_err)
);

// File: tb/isp_parser_tb.sv
module isp_parser_tb;
  localparam int WD = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] out_lockrep, out_seg;
  logic out_opsz16, out_adsz16, out_escape, out_has_modrm, out_has_sib, out_err;
  logic [7:0] out_opcode, out_modrm, out_sib;
  logic [31:0] out_disp, out_imm;
  logic [2:0] out_disp_len, out_imm_len;
  logic [3:0] out_len;

  always #10 clk = ~clk;

  isp_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_lockrep(out_lockrep), .out_seg(out_seg),
    .out_opsz16(out_opsz16), .out_adsz16(out_adsz16), .out_escape(out_escape),
    .out_opcode(out_opcode), .out_has_modrm(out_has_modrm), .out_modrm(out_modrm),
    .out_has_sib(out_has_sib), .out_sib(out_sib), .out_disp(out_disp),
    .out_disp_len(out_disp_len), .out_imm(out_imm), .out_imm_len(out_imm_len),
    .out_len(out_len), .out_err(out_err)
  );

  typedef struct {
    string       tag;
    logic [31:0] lockrep, seg, op16, ad16, esc, opcode, hm, modrm, hs, sib;
    logic [31:0] disp, dl, imm, il, len, err;
  } exp_t;

  logic [7:0] byte_q[$];
  logic [7:0] cur_q[$];
  exp_t exp_q[$];
  int nchk = 0, nfail = 0, cyc = 0;
  bit timed_out = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input string tc, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s [%s]: actual %0h expected %0h", req, tc, act, exp);
    end
  endtask

  function automatic exp_t model(input string tc);
    exp_t e;
    int i, pc, dl, il;
    logic [7:0] b;
    logic mr;
    e = '{tag: tc, default: '0};
    i = 0; pc = 0; dl = 0; il = 0; mr = 0;
    while (i < cur_q.size()) begin
      b = cur_q[i];
      if (b == 8'hF0 || b == 8'hF2 || b == 8'hF3 || b == 8'h26 || b == 8'h64 || b == 8'h66 || b == 8'h67) begin
        if (pc == 4) begin e.err = 1; e.len = i + 1; return e; end
        pc++; i++;
        if (b == 8'hF0) e.lockrep = 1;
        else if (b == 8'hF2) e.lockrep = 2;
        else if (b == 8'hF3) e.lockrep = 3;
        else if (b == 8'h26) e.seg = 1;
        else if (b == 8'h64) e.seg = 2;
        else if (b == 8'h66) e.op16 = 1;
        else e.ad16 = 1;
      end else break;
    end
    b = cur_q[i]; i++;
    if (b == 8'h0F) begin e.esc = 1; e.opcode = cur_q[i]; e.err = 1; e.len = i + 1; return e; end
    e.opcode = b;
    case (b)
      8'h00, 8'h01, 8'h02, 8'h03: mr = 1;
      8'h04: il = 1;
      8'h05: il = e.op16[0] ? 2 : 4;
      8'h80, 8'h83: begin mr = 1; il = 1; end
      8'h81: begin mr = 1; il = e.op16[0] ? 2 : 4; end
      default: begin e.err = 1; e.len = i; return e; end
    endcase
    if (mr) begin
      e.hm = 1; e.modrm = cur_q[i]; i++;
      if (e.modrm[7:6] == 2'd1) dl = 1;
      else if (e.modrm[7:6] == 2'd2) dl = 4;
      else if (e.modrm[7:6] == 2'd0 && e.modrm[2:0] == 3'd5) dl = 4;
      if (e.modrm[7:6] != 2'd3 && e.modrm[2:0] == 3'd4) begin
        e.hs = 1; e.sib = cur_q[i]; i++;
        if (e.modrm[7:6] == 2'd0 && e.sib[2:0] == 3'd5) dl = 4;
      end
    end
    for (int k = 0; k < dl; k++) begin e.disp[8*k +: 8] = cur_q[i]; i++; end
    for (int k = 0; k < il; k++) begin e.imm[8*k +: 8] = cur_q[i]; i++; end
    e.dl = dl; e.il = il; e.len = i;
    return e;
  endfunction

  task automatic seq(input string tc, input logic [127:0] bytes, input int n);
    cur_q.delete();
    for (int k = 0; k < n; k++) begin
      cur_q.push_back(bytes[8*(n-1-k) +: 8]);
      byte_q.push_back(bytes[8*(n-1-k) +: 8]);
    end
    exp_q.push_back(model(tc));
  endtask

  task automatic compare(input exp_t e);
    chk("R3", e.tag, {30'd0, out_lockrep}, e.lockrep);
    chk("R3", e.tag, {30'd0, out_seg}, e.seg);
    chk("R3", e.tag, {31'd0, out_opsz16}, e.op16);
    chk("R3", e.tag, {31'd0, out_adsz16}, e.ad16);
    chk("R5", e.tag, {31'd0, out_escape}, e.esc);
    chk("R6", e.tag, {24'd0, out_opcode}, e.opcode);
    chk("R6", e.tag, {31'd0, out_err}, e.err);
    chk("R7", e.tag, {31'd0, out_has_modrm}, e.hm);
    chk("R7", e.tag, {24'd0, out_modrm}, e.modrm);
    chk("R7", e.tag, {31'd0, out_has_sib}, e.hs);
    chk("R7", e.tag, {24'd0, out_sib}, e.sib);
    chk("R8", e.tag, {29'd0, out_disp_len}, e.dl);
    chk((e.dl == 0) ? "R12" : "R9", e.tag, out_disp, e.disp);
    chk("R10", e.tag, {29'd0, out_imm_len}, e.il);
    chk((e.il == 0) ? "R12" : "R9", e.tag, out_imm, e.imm);
    chk("R11", e.tag, {28'd0, out_len}, e.len);
  endtask

  task automatic run_stream();
    while ((byte_q.size() != 0 || exp_q.size() != 0 || out_valid) && !timed_out) begin
      @(negedge clk);
      cyc++;
      if (cyc > WD) begin
        timed_out = 1; nfail++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      if (byte_q.size() != 0 && (lfsr[5] | lfsr[7])) begin
        in_valid = 1'b1; in_byte = byte_q[0];
      end else begin
        in_valid = 1'b0; in_byte = 8'h00;
      end
      #1;
      chk("R1", "stall", {31'd0, in_ready}, {31'd0, !(out_valid && !out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R2: actual unexpected record op %0h expected none", out_opcode);
        end else compare(exp_q.pop_front());
      end
      if (in_valid && in_ready) void'(byte_q.pop_front());
    end
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset", {31'd0, out_valid}, 32'd0);
    chk("R2", "reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    seq("R7 reg", 16'h00C8, 2);
    seq("R7 reg", 16'h01C1, 2);
    seq("R7 mem", 16'h033B, 2);
    seq("R7 sib", 24'h030CBB, 3);
    seq("R8 d8", 24'h034610, 3);
    seq("R8 d32", 48'h039D78563412, 6);
    seq("R8 nobase", 48'h031544332211, 6);
    seq("R8 sibbase", 56'h032C05EFBEADDE, 7);
    seq("R10 i32", 40'h0511223344, 5);
    seq("R10 i16", 32'h6605AABB, 4);
    seq("R10 i8", 16'h047F, 2);
    seq("R10 81", 48'h81C178563412, 6);
    seq("R10 83", 24'h83C0FF, 3);
    seq("R9 sib+d8+i8", 40'h8044240805, 5);
    seq("R3 pfx", 104'hF0266667818488010203_04AABB, 13);
    seq("R11 max", 120'hF3646726818405112233_4455667788, 15);
    seq("R4 five", 40'hF2F2F2F2F3, 5);
    seq("R6 recover", 16'h02D8, 2);
    seq("R5 esc", 16'h0F01, 2);
    seq("R5 pfx esc", 24'h660F38, 3);
    seq("R6 bad", 8'h06, 1);
    seq("R6 bad pfx", 16'h6690, 2);
    seq("R6 recover", 16'h01C1, 2);
    run_stream();

    byte_q.push_back(8'h66); byte_q.push_back(8'h81);
    byte_q.push_back(8'hC1); byte_q.push_back(8'h44);
    run_stream();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R2", "midreset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    seq("R2 fresh", 40'h0511223344, 5);
    run_stream();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule